// File: doc/BRIEF.md
# Three-line vertical comb luma/chroma separator

This block takes an 8-bit composite video sample stream and separates it into luma and chroma. Each accepted sample is first split horizontally into a low band and a high band. The high band is then held in two line delays. Three vertically aligned high-band samples, one from each of three successive lines, are combined into a luma estimate for the centre line. The weights depend on the colour standard. The chroma of the centre line is its high band minus that estimate. The luma output is the centre line's low band plus the estimate.

The line length can be set at run time through a port, and the line delays are single-port style arrays with one read and one write per accepted sample. All internal values are held at 12-bit sample precision, which means four fractional bits below the 8-bit input scale. Rounding to 8 bits happens only at the outputs. A bypass select routes a separate, externally split Y/C pair through the first line delay instead of the comb result. The pair therefore leaves the block with exactly the same latency as combed video, and switching sources does not move the picture. An output-valid flag stays low after reset until the delays have been refilled.

Top module: `comb3_separator`

## Requirements
- R1: While `rst` is high at a rising clock edge (synchronous, active high), `y_out`, `c_out` and `out_valid` become 0, the internal line pointer returns to address 0, and the two-sample input history and the bypass input register are cleared to 0.
- R2: A sample is accepted on every rising edge where `smp_valid` is 1 and `rst` is 0. Counting accepted samples from m = 0 after reset, `out_valid` after acceptance m is 1 exactly when m >= 2 × `line_len`, and it never falls again until the next reset.
- R3: With L = `line_len`, the outputs registered at acceptance m describe centre sample m − L − 1. This holds in both the comb path and the bypass path.
- R4: With x(n) the composite input at acceptance n (x(n) = 0 for n < 0 since reset), the horizontal split stored at acceptance n uses 12-bit values. The low band is lo(n) = 4·(x(n) + 2·x(n−1) + x(n−2)). The high band is hi(n) = 16·x(n−1) − lo(n).
- R5: With `pal_sel` = 0 (NTSC), the luma estimate at acceptance m is est = (hi(m−2L) + 2·hi(m−L) + hi(m)) / 4.
- R6: With `pal_sel` = 1 (PAL), the luma estimate at acceptance m is est = (hi(m−2L) + hi(m)) / 2.
- R7: In comb mode, `y_out` = clamp(floor((lo(m−L) + est + 8) / 16), 0, 255).
- R8: In comb mode, `c_out` = clamp(floor((hi(m−L) − est + 8) / 16) + 128, 0, 255). Chroma is thus offset binary, with 128 meaning zero.
- R9: With `bypass_sel` = 1, `y_out` equals `yb_in` and `c_out` equals `cb_in` as sampled at acceptance m − L − 1.
- R10: On cycles without an accepted sample, `y_out`, `c_out` and `out_valid` hold their values, whatever `cv_in`, `yb_in` and `cb_in` carry.
- R11: Reset does not clear the line delays. If bypass runs for a whole number of lines before a reset and keeps the same `line_len` after it, then for acceptances m < L after the reset the outputs show `yb_in`/`cb_in` from pre-reset acceptance (pre-reset count − L + m − 1). `out_valid` stays 0 during this time.
- R12: `line_len` may be any value from 4 up to the `LINE_MAX` parameter (default 944). It is changed only while `rst` is high, and the internal pointer stays below `line_len`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Accept the input samples on this edge |
| pal_sel | input | 1 | Colour standard: 0 NTSC weights, 1 PAL weights |
| bypass_sel | input | 1 | 1 routes `yb_in`/`cb_in` through the delay instead of the comb |
| line_len | input | clog2(LINE_MAX+1) | Active samples per line |
| cv_in | input | 8 | Composite video sample |
| yb_in | input | 8 | External luma for bypass |
| cb_in | input | 8 | External chroma for bypass |
| y_out | output | 8 | Separated or bypassed luma |
| c_out | output | 8 | Separated chroma (offset 128) or bypassed chroma |
| out_valid | output | 1 | Outputs derive only from samples written since reset |

## Verification
A pointer that wraps one sample early or late shifts the vertical taps by one position. The first valid output after the delays refill would then mix in the wrong neighbours, so the fault shows at acceptance 2L rather than after a long run. A wrong tap weight, or a rounding or offset error, changes `y_out` or `c_out` on the first valid sample of a line-varying pattern. Line-alternating and saturating patterns keep such a fault from cancelling out. Stale or cleared delay contents after reset show up at once in bypass, during the first line after the reset. A lines-done counter that is off by one moves the rising edge of `out_valid` by a full line.

// File: rtl/comb3_pkg.sv
package comb3_pkg;

    // Sample width at the ports and internal working precision.
    localparam int DW    = 8;
    localparam int INT_W = 12;
    localparam int FRAC  = INT_W - DW;
    // High band is signed and needs one more bit than the low band.
    localparam int HW    = INT_W + 1;
    // Headroom for the three-tap vertical sums.
    localparam int VW    = INT_W + 4;

    typedef logic        [INT_W-1:0] lo_t;
    typedef logic signed [HW-1:0]    hi_t;

    typedef struct packed {
        lo_t lo;
        hi_t hi;
    } tap_t;

    typedef enum logic {
        STD_NTSC = 1'b0,
        STD_PAL  = 1'b1
    } std_e;

    localparam logic signed [VW-1:0] C_MID  = VW'(1 << (DW - 1));
    localparam logic signed [VW-1:0] HALF   = VW'(1 << (FRAC - 1));
    localparam logic signed [VW-1:0] TOPV   = VW'((1 << DW) - 1);

    function automatic logic signed [VW-1:0] widen(input hi_t h);
        return {{(VW-HW){h[HW-1]}}, h};
    endfunction

    // Round half up to the port scale, add an offset, clamp to 0..255.
    function automatic logic [DW-1:0] to_port(input logic signed [VW-1:0] v,
                                             input logic signed [VW-1:0] off);
        logic signed [VW-1:0] t;
        t = ((v + HALF) >>> FRAC) + off;
        if (t < 0)
            return '0;
        else if (t > TOPV)
            return '1;
        else
            return t[DW-1:0];
    endfunction

endpackage

// File: rtl/comb3_band_split.sv
module comb3_band_split
    import comb3_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          acc,
    input  logic [DW-1:0] cv_in,
    input  logic [DW-1:0] yb_in,
    input  logic [DW-1:0] cb_in,
    output tap_t          cmb_tap,
    output tap_t          byp_tap
);

    logic [DW-1:0] x1_q, x2_q, yb_q, cb_q;
    logic [DW+1:0] wsum;

    // 1-2-1 horizontal average centred on the previous sample.
    always_comb begin
        wsum        = {2'b00, cv_in} + {1'b0, x1_q, 1'b0} + {2'b00, x2_q};
        cmb_tap.lo  = {wsum, {(FRAC-2){1'b0}}};
        cmb_tap.hi  = $signed({1'b0, x1_q, {FRAC{1'b0}}}) - $signed({1'b0, cmb_tap.lo});
        byp_tap.lo  = {yb_q, {FRAC{1'b0}}};
        byp_tap.hi  = $signed({1'b0, cb_q, {FRAC{1'b0}}});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x1_q <= '0;
            x2_q <= '0;
            yb_q <= '0;
            cb_q <= '0;
        end else if (acc) begin
            x2_q <= x1_q;
            x1_q <= cv_in;
            yb_q <= yb_in;
            cb_q <= cb_in;
        end
    end

    // R4
    band_sum_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> (widen(cmb_tap.hi) + $signed({4'b0000, cmb_tap.lo}))
                == $signed({4'b0000, $past(cv_in), 4'b0000}));

endmodule

// File: rtl/comb3_line_delay.sv
module comb3_line_delay #(
    parameter  int WIDTH = 8,
    parameter  int DEPTH = 944,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data
);

    // No reset: contents survive a control reset.
    logic [WIDTH-1:0] mem [DEPTH];

    // Read returns the word written one line earlier at this address.
    assign rd_data = mem[addr];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wr_data;
    end

endmodule

// File: rtl/comb3_vcomb.sv
module comb3_vcomb
    import comb3_pkg::*;
(
    input  hi_t           h0,
    input  hi_t           h1,
    input  hi_t           h2,
    input  lo_t           lo1,
    input  logic          pal,
    input  logic          byp,
    output logic [DW-1:0] y_nxt,
    output logic [DW-1:0] c_nxt
);

    logic signed [VW-1:0] e0, e1, e2, est, vy, vc;
    std_e std_sel;

    always_comb begin
        std_sel = std_e'(pal);
        e0 = widen(h0);
        e1 = widen(h1);
        e2 = widen(h2);
        case (std_sel)
            STD_PAL:  est = (e2 + e0) >>> 1;
            default:  est = (e2 + (e1 <<< 1) + e0) >>> 2;
        endcase
        vy = $signed({{(VW-INT_W){1'b0}}, lo1}) + est;
        vc = e1 - est;
        if (byp) begin
            y_nxt = lo1[INT_W-1:FRAC];
            c_nxt = h1[INT_W-1:FRAC];
        end else begin
            y_nxt = to_port(vy, '0);
            c_nxt = to_port(vc, C_MID);
        end
    end

    // R5: a vertically flat high band leaves no chroma under NTSC weights
    always_comb begin
        flat_chroma_chk: assert (byp || pal || h0 != h1 || h1 != h2 || vc == 0);
    end

endmodule

// File: rtl/comb3_separator.sv
module comb3_separator
    import comb3_pkg::*;
#(
    parameter  int LINE_MAX = 944,
    localparam int LW       = $clog2(LINE_MAX + 1),
    localparam int AW       = $clog2(LINE_MAX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic          pal_sel,
    input  logic          bypass_sel,
    input  logic [LW-1:0] line_len,
    input  logic [DW-1:0] cv_in,
    input  logic [DW-1:0] yb_in,
    input  logic [DW-1:0] cb_in,
    output logic [DW-1:0] y_out,
    output logic [DW-1:0] c_out,
    output logic          out_valid
);

    localparam logic [1:0] LINES_NEED = 2'd2;

    logic          acc;
    logic [LW-1:0] ptr_q;
    logic [1:0]    lines_q;
    logic          wrap;
    logic [AW-1:0] addr;
    tap_t          cmb_tap, byp_tap, wr1, rd1;
    hi_t           rd2;
    logic [DW-1:0] y_nxt, c_nxt;

    assign acc  = smp_valid & ~rst;
    assign wrap = (ptr_q == line_len - LW'(1));
    assign addr = ptr_q[AW-1:0];
    assign wr1  = bypass_sel ? byp_tap : cmb_tap;

    comb3_band_split u_split (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .cv_in   (cv_in),
        .yb_in   (yb_in),
        .cb_in   (cb_in),
        .cmb_tap (cmb_tap),
        .byp_tap (byp_tap)
    );

    // First delay carries the whole tap (low band needed for the centre line).
    comb3_line_delay #(.WIDTH($bits(tap_t)), .DEPTH(LINE_MAX)) u_dly1 (
        .clk     (clk),
        .we      (acc),
        .addr    (addr),
        .wr_data (wr1),
        .rd_data (rd1)
    );

    // Second delay only needs the high band of the top line.
    comb3_line_delay #(.WIDTH(HW), .DEPTH(LINE_MAX)) u_dly2 (
        .clk     (clk),
        .we      (acc),
        .addr    (addr),
        .wr_data (rd1.hi),
        .rd_data (rd2)
    );

    comb3_vcomb u_vcomb (
        .h0    (cmb_tap.hi),
        .h1    (rd1.hi),
        .h2    (rd2),
        .lo1   (rd1.lo),
        .pal   (pal_sel),
        .byp   (bypass_sel),
        .y_nxt (y_nxt),
        .c_nxt (c_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            lines_q   <= '0;
            y_out     <= '0;
            c_out     <= '0;
            out_valid <= 1'b0;
        end else if (acc) begin
            ptr_q     <= wrap ? '0 : ptr_q + LW'(1);
            if (wrap && lines_q != LINES_NEED)
                lines_q <= lines_q + 2'd1;
            y_out     <= y_nxt;
            c_out     <= c_nxt;
            out_valid <= (lines_q == LINES_NEED);
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (y_out == '0 && c_out == '0 && !out_valid && ptr_q == '0));

    // R2
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> ($past(ptr_q) == '0 && $past(lines_q) == LINES_NEED));

    // R10
    hold_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(y_out) && $stable(c_out) && $stable(out_valid)));

    // R12
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_q < line_len);

endmodule

// File: tb/tb_comb3_separator.sv
module tb_comb3_separator;

    localparam int LINE_MAX = 944;
    localparam int LW       = $clog2(LINE_MAX + 1);
    localparam int HSZ      = 2048;

    logic          clk = 1'b0;
    logic          rst, smp_valid, pal_sel, bypass_sel;
    logic [LW-1:0] line_len;
    logic [7:0]    cv_in, yb_in, cb_in;
    logic [7:0]    y_out, c_out;
    logic          out_valid;

    always #2 clk = ~clk;

    comb3_separator #(.LINE_MAX(LINE_MAX)) dut (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .pal_sel    (pal_sel),
        .bypass_sel (bypass_sel),
        .line_len   (line_len),
        .cv_in      (cv_in),
        .yb_in      (yb_in),
        .cb_in      (cb_in),
        .y_out      (y_out),
        .c_out      (c_out),
        .out_valid  (out_valid)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int cvh [HSZ];
    int ybh [HSZ];
    int cbh [HSZ];
    int ybold [HSZ];
    int cbold [HSZ];
    int n_arr = 0;
    int n_old = 0;
    int cur_len = 4;
    bit retain_chk = 1'b0;
    int last_y, last_c, last_v;

    task automatic check(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int xv(input int n);
        return (n < 0) ? 0 : cvh[n];
    endfunction

    function automatic int lo_of(input int n);
        return 4 * (xv(n) + 2 * xv(n - 1) + xv(n - 2));
    endfunction

    function automatic int hi_of(input int n);
        return 16 * xv(n - 1) - lo_of(n);
    endfunction

    function automatic int fdiv16(input int v);
        return (v >= 0) ? v / 16 : -((-v + 15) / 16);
    endfunction

    function automatic int clamp8(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    function automatic int pat(input int k, input int sel);
        case (sel)
            0:       return (k * 7 + (k % 2) * 40) % 256;
            1:       return (k * 73 + 29) % 256;
            default: return ((k / 3) % 2) * 255;
        endcase
    endfunction

    task automatic rst_to(input int len, input bit pal, input bit byp);
        for (int i = 0; i < HSZ; i++) begin
            ybold[i] = ybh[i];
            cbold[i] = cbh[i];
        end
        n_old      = n_arr;
        n_arr      = 0;
        rst        = 1'b1;
        smp_valid  = 1'b0;
        line_len   = LW'(len);
        cur_len    = len;
        pal_sel    = pal;
        bypass_sel = byp;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 y_out after reset", int'(y_out), 0);
        check("R1 c_out after reset", int'(c_out), 0);
        check("R1 out_valid after reset", int'(out_valid), 0);
        last_y = 0; last_c = 0; last_v = 0;
    endtask

    task automatic push(input int cv, input int yb, input int cb, input string ctx);
        int m, L, est, ey, ec;
        L = cur_len;
        smp_valid = 1'b1;
        cv_in = 8'(cv); yb_in = 8'(yb); cb_in = 8'(cb);
        m = n_arr;
        cvh[m] = cv; ybh[m] = yb; cbh[m] = cb;
        n_arr++;
        @(negedge clk);
        smp_valid = 1'b0;
        // R2: refill period of two lines
        check({ctx, " R2 out_valid"}, int'(out_valid), (m >= 2 * L) ? 1 : 0);
        if (m >= 2 * L) begin
            if (bypass_sel) begin
                // R9 R3: bypass through the same delay
                check({ctx, " R9 R3 bypass y"}, int'(y_out), ybh[m - L - 1]);
                check({ctx, " R9 R3 bypass c"}, int'(c_out), cbh[m - L - 1]);
            end else begin
                if (pal_sel)
                    est = (hi_of(m - 2 * L) + hi_of(m)) / 2;
                else
                    est = (hi_of(m - 2 * L) + 2 * hi_of(m - L) + hi_of(m)) / 4;
                ey = clamp8(fdiv16(lo_of(m - L) + est + 8));
                ec = clamp8(fdiv16(hi_of(m - L) - est + 8) + 128);
                if (pal_sel) begin
                    check({ctx, " R6 R4 R3 R7 luma"}, int'(y_out), ey);
                    check({ctx, " R6 R8 chroma"}, int'(c_out), ec);
                end else begin
                    check({ctx, " R5 R4 R3 R7 luma"}, int'(y_out), ey);
                    check({ctx, " R5 R8 chroma"}, int'(c_out), ec);
                end
            end
        end else if (retain_chk && m < L) begin
            // R11: line delay contents survive reset
            check({ctx, " R11 retained y"}, int'(y_out), ybold[n_old - L + m - 1]);
            check({ctx, " R11 retained c"}, int'(c_out), cbold[n_old - L + m - 1]);
        end
        last_y = int'(y_out); last_c = int'(c_out); last_v = int'(out_valid);
    endtask

    task automatic idle(input int n);
        smp_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            cv_in = 8'(pat(i, 1)); yb_in = 8'(i * 31); cb_in = 8'(i * 17);
            @(negedge clk);
        end
        // R10: no accepted sample, nothing moves
        check("R10 y hold", int'(y_out), last_y);
        check("R10 c hold", int'(c_out), last_c);
        check("R10 valid hold", int'(out_valid), last_v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; smp_valid = 1'b0; pal_sel = 1'b0; bypass_sel = 1'b0;
        line_len = LW'(5); cv_in = '0; yb_in = '0; cb_in = '0;
        @(negedge clk);

        // NTSC, line length 5, three patterns with idle gaps
        rst_to(5, 1'b0, 1'b0);
        for (int k = 0; k < 40; k++) push(pat(k, 0), 0, 0, "ntsc ramp");
        idle(3);
        for (int k = 40; k < 60; k++) push(pat(k, 1), 0, 0, "ntsc hash");
        idle(2);
        for (int k = 60; k < 80; k++) push(pat(k, 2), 0, 0, "ntsc sat");

        // PAL, line length 6
        rst_to(6, 1'b1, 1'b0);
        for (int k = 0; k < 30; k++) push(pat(k, 1), 0, 0, "pal hash");
        for (int k = 30; k < 54; k++) push(pat(k, 2), 0, 0, "pal sat");
        idle(4);
        for (int k = 54; k < 70; k++) push(pat(k, 0), 0, 0, "pal ramp");

        // Bypass, line length 4, then reset on a line boundary
        rst_to(4, 1'b0, 1'b1);
        for (int k = 0; k < 20; k++) push(pat(k, 2), pat(k, 1), pat(k, 0), "bypass");
        rst_to(4, 1'b0, 1'b1);
        retain_chk = 1'b1;
        for (int k = 0; k < 12; k++) push(pat(k, 0), pat(k + 5, 0), pat(k + 9, 1), "bypass post reset");
        retain_chk = 1'b0;

        // R12: longest line, bypass
        rst_to(LINE_MAX, 1'b0, 1'b1);
        for (int k = 0; k < 2 * LINE_MAX + 6; k++)
            push(pat(k, 0), pat(k, 1), pat(k + 3, 1), "R12 max line");

        // R12: shortest line, NTSC
        rst_to(4, 1'b0, 1'b0);
        for (int k = 0; k < 24; k++) push(pat(k, 1), 0, 0, "R12 min line");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule